// File: doc/BRIEF.md
# Floating-Point Addition Special-Case Resolver

This combinational block sits in front of a single-precision adder. It sorts each of the two operands into one of six classes: zero, normal, denormal, infinity, quiet NaN or signalling NaN. From the pair of classes it decides whether the sum is already known. If it is, the block drives the finished result word and raises the bypass flag. If it is not, it raises the proceed flag so that the arithmetic datapath performs alignment, addition, normalization and rounding.

NaN operands follow a fixed priority. A signalling NaN in the second operand wins over one in the first, and a reported signalling NaN leaves the block quieted. Infinities and zeros are handled without arithmetic. The rounding mode has one use here: it sets the sign of the exact zero produced when two zeros of opposite sign are added.

Top module: `fadd_special_resolve`

## Requirements
- R1: Operand classes are decoded from the fields (sign bit 31, exponent bits 30:23, fraction bits 22:0). An all-ones exponent with a zero fraction is infinity. An all-ones exponent with a nonzero fraction is a NaN, quiet when fraction bit 22 is set and signalling when it is clear. A zero exponent with a nonzero fraction is denormal. A zero exponent with a zero fraction is zero. Every other exponent is normal.
- R2: When operand b is a signalling NaN, the result is b with fraction bit 22 set, invalid_o is 1 and bypass_o is 1, whatever operand a is.
- R3: When operand a is a signalling NaN and b is not, the result is a with fraction bit 22 set and invalid_o is 1.
- R4: When no signalling NaN is present and at least one operand is a quiet NaN, the quiet NaN is returned unchanged with invalid_o at 0. If both operands are quiet NaNs, operand a is returned.
- R5: Infinity plus infinity of the same sign returns operand a. With opposite signs the result is 0x7FC00000 and invalid_o is 1.
- R6: Infinity plus a zero, normal or denormal operand returns the infinity operand unchanged.
- R7: Zero plus zero of the same sign returns operand a. With opposite signs the result is 0x00000000, except when rmode_i is 2'b11 (round toward minus infinity), where it is 0x80000000.
- R8: A zero plus a nonzero finite operand (normal or denormal) returns the nonzero operand unchanged.
- R9: When both operands are normal or denormal, proceed_o is 1, bypass_o is 0, invalid_o is 0 and result_o is 0.
- R10: Exactly one of bypass_o and proceed_o is 1 for every input, and invalid_o is 1 only together with bypass_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 32 | First operand, single-precision word |
| b_i | input | 32 | Second operand, single-precision word |
| rmode_i | input | 2 | Rounding mode; 2'b11 is round toward minus infinity |
| bypass_o | output | 1 | Result decided here; result_o is valid |
| result_o | output | 32 | Decided result word (zero when proceeding) |
| invalid_o | output | 1 | Invalid-operation exception |
| proceed_o | output | 1 | Pair must go to the arithmetic datapath |

## Verification
The assertions assume only that the inputs are settled two-state words. All 2^32 bit patterns are legal operands, so they constrain no input value and hold for every class pair and every rounding mode. The stimulus walks every one of the 36 class pairs. It uses two representatives per class, with both signs and payloads at the edges of the fraction field, and repeats them under all four rounding-mode codes. As a result, the mode-dependent zero sign and the NaN ordering are each reached from several directions.

// File: rtl/fadd_sr_pkg.sv
package fadd_sr_pkg;
   // Operand class; the numeric order carries no meaning.
   typedef enum logic [2:0] {
      OPC_ZERO  = 3'd0,
      OPC_NORM  = 3'd1,
      OPC_DNORM = 3'd2,
      OPC_INF   = 3'd3,
      OPC_QNAN  = 3'd4,
      OPC_SNAN  = 3'd5
   } opclass_e;

   function automatic logic is_nan(input opclass_e c);
      return (c == OPC_QNAN) || (c == OPC_SNAN);
   endfunction

   function automatic logic is_finite_nz(input opclass_e c);
      return (c == OPC_NORM) || (c == OPC_DNORM);
   endfunction
endpackage

// File: rtl/fadd_sr_classify.sv
module fadd_sr_classify
   import fadd_sr_pkg::*;
#(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23,
   localparam int W     = 1 + EXP_W + FRAC_W
) (
   input  logic [W-1:0] op_i,
   output opclass_e     cls_o
);
   logic [EXP_W-1:0]  exp_f;
   logic [FRAC_W-1:0] frac_f;

   assign exp_f  = op_i[W-2 -: EXP_W];
   assign frac_f = op_i[FRAC_W-1:0];

   always_comb begin
      if (&exp_f) begin
         if (frac_f == '0)               cls_o = OPC_INF;
         else if (frac_f[FRAC_W-1])      cls_o = OPC_QNAN;
         else                            cls_o = OPC_SNAN;
      end else if (exp_f == '0) begin
         cls_o = (frac_f == '0) ? OPC_ZERO : OPC_DNORM;
      end else begin
         cls_o = OPC_NORM;
      end
   end
endmodule

// File: rtl/fadd_sr_quieten.sv
module fadd_sr_quieten #(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23,
   localparam int W     = 1 + EXP_W + FRAC_W
) (
   input  logic [W-1:0] nan_i,
   output logic [W-1:0] quiet_o
);
   localparam logic [W-1:0] QBIT = W'(1) << (FRAC_W - 1);
   assign quiet_o = nan_i | QBIT;
endmodule

// File: rtl/fadd_sr_pair.sv
module fadd_sr_pair
   import fadd_sr_pkg::*;
#(
   parameter int EXP_W        = 8,
   parameter int FRAC_W       = 23,
   parameter bit SNAN_B_FIRST = 1'b1,
   localparam int W           = 1 + EXP_W + FRAC_W
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  opclass_e     cls_a_i,
   input  opclass_e     cls_b_i,
   input  logic         rm_down_i,
   output logic         bypass_o,
   output logic [W-1:0] result_o,
   output logic         invalid_o
);
   localparam logic [W-1:0] DEF_NAN =
      {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

   logic [W-1:0] ops [2];
   logic [W-1:0] qops [2];
   logic         snan_any;
   logic [W-1:0] snan_word;
   logic         sign_a, sign_b;

   assign ops[0] = a_i;
   assign ops[1] = b_i;
   assign sign_a = a_i[W-1];
   assign sign_b = b_i[W-1];

   for (genvar k = 0; k < 2; k++) begin : g_quiet
      fadd_sr_quieten #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_q (
         .nan_i  (ops[k]),
         .quiet_o(qops[k])
      );
   end

   // Signalling-NaN ordering variant.
   if (SNAN_B_FIRST) begin : g_snan_b
      always_comb begin
         snan_any  = 1'b1;
         if (cls_b_i == OPC_SNAN)      snan_word = qops[1];
         else if (cls_a_i == OPC_SNAN) snan_word = qops[0];
         else begin
            snan_any  = 1'b0;
            snan_word = '0;
         end
      end
   end else begin : g_snan_a
      always_comb begin
         snan_any  = 1'b1;
         if (cls_a_i == OPC_SNAN)      snan_word = qops[0];
         else if (cls_b_i == OPC_SNAN) snan_word = qops[1];
         else begin
            snan_any  = 1'b0;
            snan_word = '0;
         end
      end
   end

   always_comb begin
      bypass_o  = 1'b1;
      invalid_o = 1'b0;
      result_o  = '0;
      if (snan_any) begin
         result_o  = snan_word;
         invalid_o = 1'b1;
      end else if (cls_a_i == OPC_QNAN) begin
         result_o = a_i;
      end else if (cls_b_i == OPC_QNAN) begin
         result_o = b_i;
      end else if (cls_a_i == OPC_INF && cls_b_i == OPC_INF) begin
         if (sign_a == sign_b) result_o = a_i;
         else begin
            result_o  = DEF_NAN;
            invalid_o = 1'b1;
         end
      end else if (cls_a_i == OPC_INF) begin
         result_o = a_i;
      end else if (cls_b_i == OPC_INF) begin
         result_o = b_i;
      end else if (cls_a_i == OPC_ZERO && cls_b_i == OPC_ZERO) begin
         result_o = (sign_a == sign_b) ? a_i : {rm_down_i, {(W-1){1'b0}}};
      end else if (cls_a_i == OPC_ZERO) begin
         result_o = b_i;
      end else if (cls_b_i == OPC_ZERO) begin
         result_o = a_i;
      end else begin
         bypass_o = 1'b0;
      end
   end

   // Guards on the decided result.
   always_comb begin
      if (cls_a_i == OPC_ZERO && cls_b_i == OPC_ZERO)
         assert_zero_mag_R7: assert (result_o[W-2:0] == '0)
            else $error("zero pair gave nonzero magnitude");
      if (bypass_o && is_finite_nz(cls_a_i) && cls_b_i == OPC_ZERO)
         assert_keep_nonzero_R8: assert (result_o == a_i)
            else $error("zero operand altered the nonzero operand");
      if (is_finite_nz(cls_a_i) && is_finite_nz(cls_b_i))
         assert_datapath_pair_R9: assert (!bypass_o)
            else $error("finite nonzero pair bypassed");
   end
endmodule

// File: rtl/fadd_special_resolve.sv
module fadd_special_resolve
   import fadd_sr_pkg::*;
#(
   parameter int EXP_W        = 8,
   parameter int FRAC_W       = 23,
   parameter int RM_W         = 2,
   parameter int RM_DOWN      = 3,
   parameter bit SNAN_B_FIRST = 1'b1
) (
   input  logic [EXP_W+FRAC_W:0] a_i,
   input  logic [EXP_W+FRAC_W:0] b_i,
   input  logic [RM_W-1:0]       rmode_i,
   output logic                  bypass_o,
   output logic [EXP_W+FRAC_W:0] result_o,
   output logic                  invalid_o,
   output logic                  proceed_o
);
   localparam int W = 1 + EXP_W + FRAC_W;

   if (EXP_W < 2)  begin : g_bad_exp  $error("EXP_W must be at least 2");  end
   if (FRAC_W < 2) begin : g_bad_frac $error("FRAC_W must be at least 2"); end
   if (RM_DOWN >= (1 << RM_W)) begin : g_bad_rm
      $error("RM_DOWN does not fit in RM_W bits");
   end

   opclass_e     cls [2];
   logic [W-1:0] ops [2];
   logic         rm_down;
   logic         byp;

   assign ops[0]  = a_i;
   assign ops[1]  = b_i;
   assign rm_down = (rmode_i == RM_W'(RM_DOWN));

   for (genvar k = 0; k < 2; k++) begin : g_cls
      fadd_sr_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
         .op_i (ops[k]),
         .cls_o(cls[k])
      );
   end

   fadd_sr_pair #(
      .EXP_W(EXP_W), .FRAC_W(FRAC_W), .SNAN_B_FIRST(SNAN_B_FIRST)
   ) u_pair (
      .a_i      (a_i),
      .b_i      (b_i),
      .cls_a_i  (cls[0]),
      .cls_b_i  (cls[1]),
      .rm_down_i(rm_down),
      .bypass_o (byp),
      .result_o (result_o),
      .invalid_o(invalid_o)
   );

   assign bypass_o  = byp;
   assign proceed_o = ~byp;

   always_comb begin
      assert_one_path_R10: assert (bypass_o != proceed_o)
         else $error("bypass and proceed not exclusive");
      assert_invalid_bypass_R10: assert (!invalid_o || bypass_o)
         else $error("invalid raised without bypass");
      if (proceed_o)
         assert_proceed_clean_R9: assert (result_o == '0 && !invalid_o)
            else $error("proceed with stray result");
      if (bypass_o && (&result_o[W-2 -: EXP_W]) && result_o[FRAC_W-1:0] != '0)
         assert_nan_quiet_R4: assert (result_o[FRAC_W-1])
            else $error("signalling NaN left the block");
      if (cls[1] == OPC_SNAN && SNAN_B_FIRST)
         assert_snan_b_R2: assert (invalid_o && result_o[W-2:0] == (b_i[W-2:0] | (W-1)'(1) << (FRAC_W-1)))
            else $error("b signalling NaN not reported");
      if (is_nan(cls[0]) || is_nan(cls[1]))
         assert_nan_bypass_R3: assert (bypass_o)
            else $error("NaN operand sent to datapath");
   end
endmodule

// File: tb/sim_fadd_special_resolve.sv
module sim_fadd_special_resolve;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] a, b;
   logic [1:0]  rm;
   logic        bypass, invalid, proceed;
   logic [31:0] result;
   int          total = 0;
   int          fails = 0;
   int          cycles = 0;

   always #4 clk = ~clk;   // 125 MHz

   fadd_special_resolve u0 (
      .a_i(a), .b_i(b), .rmode_i(rm),
      .bypass_o(bypass), .result_o(result),
      .invalid_o(invalid), .proceed_o(proceed)
   );

   // 0 zero, 1 normal, 2 denormal, 3 infinity, 4 quiet NaN, 5 signalling NaN
   function automatic int kind(input logic [31:0] x);
      int e = int'(x[30:23]);
      int f = int'(x[22:0]);
      if (e == 255) return (f == 0) ? 3 : ((f >= 4194304) ? 4 : 5);
      if (e == 0)   return (f == 0) ? 0 : 2;
      return 1;
   endfunction

   function automatic void model(input logic [31:0] x, input logic [31:0] y,
                                 input logic [1:0] m, output logic e_byp,
                                 output logic [31:0] e_res, output logic e_inv,
                                 output string tag);
      int kx = kind(x);
      int ky = kind(y);
      e_byp = 1'b1; e_inv = 1'b0; e_res = 32'h0;
      if (ky == 5)              begin e_res = y | 32'h0040_0000; e_inv = 1'b1; tag = "R2"; end
      else if (kx == 5)         begin e_res = x | 32'h0040_0000; e_inv = 1'b1; tag = "R3"; end
      else if (kx == 4)         begin e_res = x; tag = "R4"; end
      else if (ky == 4)         begin e_res = y; tag = "R4"; end
      else if (kx == 3 && ky == 3) begin
         tag = "R5";
         if (x[31] == y[31]) e_res = x;
         else begin e_res = 32'h7FC0_0000; e_inv = 1'b1; end
      end
      else if (kx == 3)         begin e_res = x; tag = "R6"; end
      else if (ky == 3)         begin e_res = y; tag = "R6"; end
      else if (kx == 0 && ky == 0) begin
         tag = "R7";
         e_res = (x[31] == y[31]) ? x : ((m == 2'b11) ? 32'h8000_0000 : 32'h0);
      end
      else if (kx == 0)         begin e_res = y; tag = "R8"; end
      else if (ky == 0)         begin e_res = x; tag = "R8"; end
      else                      begin e_byp = 1'b0; tag = "R9"; end
   endfunction

   task automatic check_vec(input logic [31:0] x, input logic [31:0] y,
                            input logic [1:0] m, input string note);
      logic        e_byp, e_inv;
      logic [31:0] e_res;
      string       tag;
      @(posedge clk);
      a = x; b = y; rm = m;
      @(negedge clk);
      model(x, y, m, e_byp, e_res, e_inv, tag);
      total++;
      if (bypass !== e_byp || result !== e_res || invalid !== e_inv) begin
         fails++;
         $display("FAIL %s%s a=%h b=%h rm=%0d: got byp=%b res=%h inv=%b exp byp=%b res=%h inv=%b",
                  tag, note, x, y, m, bypass, result, invalid, e_byp, e_res, e_inv);
      end
      total++;   // R10 path exclusivity
      if (proceed !== ~e_byp || (invalid && !bypass)) begin
         fails++;
         $display("FAIL R10 a=%h b=%h: got byp=%b proc=%b inv=%b exp proc=%b",
                  x, y, bypass, proceed, invalid, ~e_byp);
      end
   endtask

   logic [31:0] reps [12];

   initial begin
      reps[0]  = 32'h0000_0000; reps[1]  = 32'h8000_0000;   // zero
      reps[2]  = 32'h3F80_0000; reps[3]  = 32'hC049_0FDB;   // normal
      reps[4]  = 32'h0000_0001; reps[5]  = 32'h807F_FFFF;   // denormal
      reps[6]  = 32'h7F80_0000; reps[7]  = 32'hFF80_0000;   // infinity
      reps[8]  = 32'h7FC1_2345; reps[9]  = 32'hFFE0_0001;   // quiet NaN
      reps[10] = 32'h7F80_0001; reps[11] = 32'hFFA0_0000;   // signalling NaN
      a = '0; b = '0; rm = '0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;

      // Idle state after reset: +0 plus +0 resolves here.
      @(negedge clk);
      total++;
      if (!(bypass === 1'b1 && result === 32'h0 && invalid === 1'b0 && proceed === 1'b0)) begin
         fails++;
         $display("FAIL R7 idle: got byp=%b res=%h exp byp=1 res=00000000", bypass, result);
      end

      // Directed corners.
      check_vec(32'h7F80_0000, 32'h3F80_0000, 2'd0, " R1 inf not NaN");
      check_vec(32'h0000_0001, 32'h0000_0000, 2'd0, " R1 denorm not zero");
      check_vec(32'h7FBF_FFFF, 32'h7FC0_0000, 2'd0, " R1 bit22 clear is signalling");
      check_vec(32'h7F80_0001, 32'h7FA0_0000, 2'd0, " R2 both signalling");
      check_vec(32'h7F80_0001, 32'h7FC0_0000, 2'd0, " R3 a signalling");
      check_vec(32'h7FC0_0001, 32'hFFC0_0002, 2'd0, " R4 both quiet");
      check_vec(32'h7F80_0000, 32'hFF80_0000, 2'd1, " R5 opposite infinities");
      check_vec(32'h0080_0000, 32'hFF80_0000, 2'd2, " R6 finite plus inf");
      check_vec(32'h0000_0000, 32'h8000_0000, 2'd3, " R7 round down");
      check_vec(32'h8000_0000, 32'h0000_0000, 2'd2, " R7 round up");
      check_vec(32'h8000_0000, 32'h807F_FFFF, 2'd0, " R8 zero plus denorm");
      check_vec(32'h0000_0001, 32'h807F_FFFF, 2'd0, " R9 denorm pair");

      // Every class pair, both representatives, every rounding mode.
      for (int m = 0; m < 4; m++)
         for (int i = 0; i < 12; i++)
            for (int j = 0; j < 12; j++)
               check_vec(reps[i], reps[j], 2'(m), "");

      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         total++;
         fails++;
         $display("FAIL watchdog: got %0d cycles exp fewer", cycles);
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end
endmodule